// File: doc/BRIEF.md
# Dual-Mode Burst Address Generator

This block supplies the word address for each beat of a four-beat burst in a synchronous burst memory. A start address is captured whenever either of two active-low load strobes is sampled low on a rising clock edge. Beat zero uses that captured address unchanged. Each later rising edge with the active-low advance input low moves to the next beat. When advance is high, the current address is held, so the memory sees a wait cycle.

Only the two lowest address bits are sequenced. The upper bits stay at the value captured at load. A mode input, sampled at load, picks the beat order. When it is high, the order is interleaved: the low bits are the start bits XORed with the beat index. When it is low, the order is linear: the low bits are the start bits plus the beat index, wrapping within the four-word block. Advancing past the fourth beat keeps wrapping in the same block. The burst never stops by itself.

Top module: `burst_addr_seq`

## Requirements
- R1: A rising edge with rst_n low sets addr_out to zero and beat_idx to zero.
- R2: A rising edge with load_a_n low or load_b_n low captures addr_in. From the next cycle, addr_out equals the captured value and beat_idx is 0.
- R3: For a burst loaded with order_sel = 1 (interleaved), addr_out[1:0] equals start[1:0] XOR beat_idx. For example, start 2'b10 gives 10, 11, 00, 01.
- R4: For a burst loaded with order_sel = 0 (linear), addr_out[1:0] equals (start[1:0] + beat_idx) mod 4. For example, start 2'b11 gives 11, 00, 01, 10.
- R5: A rising edge with adv_n low and no load strobe low raises beat_idx by one modulo 4. After beat 3 it returns to beat 0 in the same four-word block.
- R6: A rising edge with adv_n high and no load strobe low leaves addr_out and beat_idx unchanged.
- R7: addr_out bits above bit 1 change only on a load. A change on addr_in between loads has no effect on addr_out.
- R8: order_sel is used only on a load edge. Changing order_sel in the middle of a burst does not change the addresses of that burst.
- R9: When a load strobe and adv_n are low on the same edge, the load wins: beat_idx becomes 0 and addr_out equals addr_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_a_n | input | 1 | First active-low start-address strobe |
| load_b_n | input | 1 | Second active-low start-address strobe |
| adv_n | input | 1 | Active-low beat advance |
| order_sel | input | 1 | Beat order taken at load: 1 = interleaved, 0 = linear |
| addr_in | input | ADDR_W | External start address |
| addr_out | output | ADDR_W | Address of the current beat |
| beat_idx | output | 2 | Index of the current beat, 0 to 3 |

## Verification
The bench loads start values whose two low bits differ between the two orders. This separates an XOR map from an adder map, and a design that swapped the two orders or used the live mode pin instead of the captured one would give wrong middle beats. It toggles order_sel and addr_in in the middle of a burst, which catches a design that samples either input outside a load. It advances past the fourth beat, where a saturating counter would stick at beat 3. It drives a load and an advance on the same edge, where a design that gave advance priority would start the burst at beat 1. Long runs of wait cycles catch a counter that steps without advance.

// File: rtl/burst_seq_pkg.sv
// Package: burst_seq_pkg
// Types and constants shared by the burst address generator.
// Assumes a burst length that is a power of two.
package burst_seq_pkg;

    // Beat ordering chosen when a burst is loaded.
    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_order_e;

    // Default number of beats in one burst.
    localparam int BURST_BEATS = 4;

endpackage

// File: rtl/burst_start_reg.sv
// Module: burst_start_reg
// Holds the start address and the beat order of the current burst.
// Both are taken when load is high. The upper address bits stay fixed
// until the next load. Assumes a synchronous active-low reset.
module burst_start_reg
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LOW_W  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [ADDR_W-1:0]       addr_in,
    input  logic                    order_sel,
    output logic [ADDR_W-LOW_W-1:0] upper_q,
    output logic [LOW_W-1:0]        start_lo_q,
    output burst_order_e            order_q
);

    // Purpose: capture the start address and the order on load; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper_q    <= '0;
            start_lo_q <= '0;
            order_q    <= ORD_INTERLEAVE;
        end else if (load) begin
            upper_q    <= addr_in[ADDR_W-1:LOW_W];
            start_lo_q <= addr_in[LOW_W-1:0];
            order_q    <= burst_order_e'(order_sel);
        end
    end

    // R2: a load captures the start address.
    p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> ({upper_q, start_lo_q} == $past(addr_in)));

    // R8: outside a load, the order never moves.
    p_order_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(order_q));

endmodule

// File: rtl/burst_beat_ctr.sv
// Module: burst_beat_ctr
// Beat counter of a burst. Load restarts it at zero and has priority
// over advance. Advance steps it modulo 2**CNT_W. Otherwise it holds.
// Assumes a synchronous active-low reset.
module burst_beat_ctr #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             adv,
    output logic [CNT_W-1:0] beat_q
);

    // Purpose: restart, step or hold the beat index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q <= '0;
        end else if (load) begin
            beat_q <= '0;
        end else if (adv) begin
            beat_q <= beat_q + 1'b1;
        end
    end

    // R9: a load restarts the beat index even while advance is low.
    p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (beat_q == '0));

    // R5: an advance with no load steps the index by one, wrapping.
    p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && adv) |=> (beat_q == CNT_W'($past(beat_q) + 1'b1)));

    // R6: with neither load nor advance, the index holds.
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !adv) |=> $stable(beat_q));

endmodule

// File: rtl/burst_order_map.sv
// Module: burst_order_map
// Maps the start low bits and the beat index to the low address bits.
// Interleaved order XORs them. Linear order adds them, wrapping within
// the block. Purely combinational.
module burst_order_map
    import burst_seq_pkg::*;
#(
    parameter int LOW_W = 2
) (
    input  logic [LOW_W-1:0] start_lo,
    input  logic [LOW_W-1:0] beat,
    input  burst_order_e     order,
    output logic [LOW_W-1:0] low_out
);

    logic [LOW_W-1:0] xor_lo;
    logic [LOW_W-1:0] sum_lo;

    // Interleaved candidate, one XOR per bit.
    for (genvar b = 0; b < LOW_W; b++) begin : g_xor_bit
        assign xor_lo[b] = start_lo[b] ^ beat[b];
    end

    // Purpose: linear candidate; the add wraps at the block width.
    always_comb begin
        sum_lo = start_lo + beat;
    end

    // Purpose: choose the candidate that matches the captured order.
    always_comb begin
        unique case (order)
            ORD_INTERLEAVE: low_out = xor_lo;
            default:        low_out = sum_lo;
        endcase
    end

endmodule

// File: rtl/burst_addr_seq.sv
// Module: burst_addr_seq
// Top of the burst address generator. Either active-low strobe loads a
// start address. Active-low advance steps through the beats in
// interleaved or linear order, and advance high inserts a wait cycle.
// Assumes a power-of-two burst length and that strobes are synchronous.
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BEATS  = BURST_BEATS
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_a_n,
    input  logic                     load_b_n,
    input  logic                     adv_n,
    input  logic                     order_sel,
    input  logic [ADDR_W-1:0]        addr_in,
    output logic [ADDR_W-1:0]        addr_out,
    output logic [$clog2(BEATS)-1:0] beat_idx
);

    localparam int LOW_W = $clog2(BEATS);
    localparam int UP_W  = ADDR_W - LOW_W;

    logic             load;
    logic             adv;
    logic [UP_W-1:0]  upper_q;
    logic [LOW_W-1:0] start_lo_q;
    logic [LOW_W-1:0] beat_q;
    logic [LOW_W-1:0] low_bits;
    burst_order_e     order_q;

    // Purpose: merge the two strobes and turn the controls active-high.
    always_comb begin
        load = !load_a_n || !load_b_n;
        adv  = !adv_n;
    end

    burst_start_reg #(.ADDR_W(ADDR_W), .LOW_W(LOW_W)) u_start (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .addr_in   (addr_in),
        .order_sel (order_sel),
        .upper_q   (upper_q),
        .start_lo_q(start_lo_q),
        .order_q   (order_q)
    );

    burst_beat_ctr #(.CNT_W(LOW_W)) u_beat (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .adv   (adv),
        .beat_q(beat_q)
    );

    burst_order_map #(.LOW_W(LOW_W)) u_map (
        .start_lo(start_lo_q),
        .beat    (beat_q),
        .order   (order_q),
        .low_out (low_bits)
    );

    // Purpose: put together the output address and the beat index.
    always_comb begin
        addr_out = {upper_q, low_bits};
        beat_idx = beat_q;
    end

    // R7: outside a load, the upper address bits are stable.
    p_upper_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(addr_out[ADDR_W-1:LOW_W]));

    // R6: a wait cycle repeats the whole address.
    p_wait_repeat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !adv) |=> $stable(addr_out));

    // R2: the first beat after a load is the external address.
    p_first_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (addr_out == $past(addr_in)));

endmodule

// File: tb/burst_addr_seq_bench.sv
`timescale 1ns/1ps
module burst_addr_seq_bench;

    localparam int AW = 16;

    typedef struct {
        logic [AW-1:0] addr;
        logic [1:0]    beat;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_a_n = 1'b1;
    logic          load_b_n = 1'b1;
    logic          adv_n = 1'b1;
    logic          order_sel = 1'b1;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] addr_out;
    logic [1:0]    beat_idx;

    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;
    exp_t q[$];

    // Reference model state, written only from the requirements.
    logic [AW-1:0] m_start = '0;
    logic [1:0]    m_beat = '0;
    logic          m_mode = 1'b1;

    always #2.5 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW)) u_burst_addr_seq (
        .clk(clk), .rst_n(rst_n), .load_a_n(load_a_n), .load_b_n(load_b_n),
        .adv_n(adv_n), .order_sel(order_sel), .addr_in(addr_in),
        .addr_out(addr_out), .beat_idx(beat_idx)
    );

    function automatic logic [AW-1:0] model_addr();
        logic [1:0] lo;
        lo = m_mode ? (m_start[1:0] ^ m_beat) : (m_start[1:0] + m_beat);
        return {m_start[AW-1:2], lo};
    endfunction

    // Driver: drives one cycle at the falling edge and queues the expected result.
    task automatic cycle(input logic rn, input logic la, input logic lb, input logic av,
                         input logic md, input logic [AW-1:0] a, input string tag);
        exp_t e;
        @(negedge clk);
        rst_n = rn; load_a_n = la; load_b_n = lb; adv_n = av;
        order_sel = md; addr_in = a;
        if (!rn) begin
            m_start = '0; m_beat = '0; m_mode = 1'b1;
        end else if (!la || !lb) begin
            m_start = a; m_beat = '0; m_mode = md;
        end else if (!av) begin
            m_beat = m_beat + 2'd1;
        end
        e.addr = model_addr();
        e.beat = m_beat;
        e.tag  = tag;
        q.push_back(e);
    endtask

    // Monitor: samples after each rising edge and compares with the queue.
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (addr_out !== e.addr) begin
                failures++;
                $display("FAIL %s addr_out actual=%h expected=%h", e.tag, addr_out, e.addr);
            end
            checks++;
            if (beat_idx !== e.beat) begin
                failures++;
                $display("FAIL %s beat_idx actual=%0d expected=%0d", e.tag, beat_idx, e.beat);
            end
        end
    end

    initial begin
        // R1: reset, with addr_in busy and a load strobe low.
        cycle(0, 0, 1, 0, 0, 16'hFFFF, "R1");
        cycle(0, 1, 1, 1, 1, 16'h1234, "R1");
        // R3: interleaved from start 10, then a wrap past the fourth beat (R5).
        cycle(1, 0, 1, 1, 1, 16'hABC2, "R3");
        cycle(1, 1, 1, 0, 1, 16'h0000, "R3");
        cycle(1, 1, 1, 0, 1, 16'h0000, "R3");
        cycle(1, 1, 1, 0, 1, 16'h0000, "R3");
        cycle(1, 1, 1, 0, 1, 16'h0000, "R5");
        cycle(1, 1, 1, 0, 1, 16'h0000, "R5");
        // R4: linear from start 11, loaded through the second strobe (R2).
        cycle(1, 1, 0, 1, 0, 16'h5A03, "R2");
        cycle(1, 1, 1, 0, 0, 16'h5A03, "R4");
        cycle(1, 1, 1, 0, 0, 16'h5A03, "R4");
        cycle(1, 1, 1, 0, 0, 16'h5A03, "R4");
        cycle(1, 1, 1, 0, 0, 16'h5A03, "R5");
        // R6: wait cycles in the middle of a burst.
        cycle(1, 0, 1, 1, 1, 16'h0011, "R2");
        cycle(1, 1, 1, 0, 1, 16'h0011, "R3");
        cycle(1, 1, 1, 1, 1, 16'h0011, "R6");
        cycle(1, 1, 1, 1, 1, 16'h0011, "R6");
        cycle(1, 1, 1, 0, 1, 16'h0011, "R3");
        // R8 and R7: order_sel and addr_in move while the burst runs.
        cycle(1, 0, 1, 1, 0, 16'h7F01, "R2");
        cycle(1, 1, 1, 0, 1, 16'hFFFE, "R8");
        cycle(1, 1, 1, 0, 1, 16'h0003, "R8");
        cycle(1, 1, 1, 1, 1, 16'hC0DE, "R7");
        cycle(1, 1, 1, 0, 0, 16'h1111, "R7");
        // R9: load and advance low on the same edge.
        cycle(1, 1, 1, 0, 1, 16'h0000, "R5");
        cycle(1, 0, 1, 0, 1, 16'h4442, "R9");
        cycle(1, 1, 0, 0, 0, 16'h9991, "R9");
        cycle(1, 1, 1, 0, 0, 16'h9991, "R4");
        // R1: reset in the middle of a burst.
        cycle(0, 1, 1, 0, 1, 16'h9991, "R1");
        cycle(1, 1, 1, 1, 1, 16'h9991, "R6");
        cycle(1, 1, 1, 1, 1, 16'h9991, "R6");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run is counted as a failure and still prints the summary.
    initial begin
        #50000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule